// File: doc/BRIEF.md
# Object Hash Table Lookup Engine

The engine resolves a graphics object name into its stored context. A requester presents a 32-bit object name and the active channel number. The engine folds the name and channel into an 8-bit hash. It turns the hash into a 16-byte slot inside a hash table whose base address and size are configurable. It then fetches the two context words of that slot over a synchronous 32-bit memory read port. The first word is the stored name and the second is a packed descriptor.

When the stored name equals the requested one and the descriptor is non-zero, the engine returns a hit with the descriptor unpacked into its fields. These are the class, channel, subchannel, instance offset and a flag that marks software-injected objects. Any other outcome is a miss.

A separate combinational path maps an address in the instance area to a physical memory address. Instance blocks of 16 bytes are laid out from the top of memory downward.

Top module: `obj_lookup`

## Requirements
- R1: The hash is the XOR of name bytes [7:0], [15:8], [23:16] and [31:24] with the channel number zero-extended to 8 bits.
- R2: The first read of a lookup goes to slot address = aligned base + hash × 16. The second read goes to that address + 4. Exactly two reads are issued per lookup, on consecutive cycles.
- R3: The table base is aligned down to the table size selected by tbl_size_i: 0 → 4 KB, 1 → 8 KB, 2 → 16 KB, 3 → 32 KB. The masked slot offset is then added.
- R4: Read data arrives one cycle after its address. A request accepted at clock edge k produces rsp_valid_o high for exactly the one cycle that follows edge k+3.
- R5: A hit is reported only when the first word read equals the requested name and the second word (the descriptor) is non-zero.
- R6: On a hit the descriptor fields are returned as follows: instance offset from bits [15:0], class from [22:16], subchannel from [26:24], channel from [30:28], and the software flag from bit 31.
- R7: On a miss, all decoded field outputs are zero.
- R8: req_ready_o is high only while the engine is idle, so no request is accepted between acceptance and the end of the response cycle.
- R9: xlat_addr_o equals xlat_addr_i XOR (2^MEM_AW − 16), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Engine idle, request accepted on this edge |
| req_name_i | input | 32 | Object name to look up |
| req_chan_i | input | CHAN_W | Active channel number |
| tbl_base_i | input | MEM_AW | Hash table base byte address |
| tbl_size_i | input | 2 | Table size select (4/8/16/32 KB) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | MEM_AW | Memory byte address |
| mem_data_i | input | 32 | Read data, one cycle after address |
| rsp_valid_o | output | 1 | Response valid for one cycle |
| rsp_hit_o | output | 1 | Name matched and descriptor non-zero |
| rsp_sw_o | output | 1 | Software-injected object flag |
| rsp_chan_o | output | 3 | Stored channel field |
| rsp_subch_o | output | 3 | Stored subchannel field |
| rsp_class_o | output | 7 | Stored class field |
| rsp_inst_o | output | 16 | Stored instance offset |
| xlat_addr_i | input | MEM_AW | Instance-area address |
| xlat_addr_o | output | MEM_AW | Translated physical address |

## Verification
The bound assertions check the protocol on every cycle:
- The response lasts one cycle and never coincides with readiness.
- An accepted request is followed by a read.
- The two reads are four bytes apart and start on a 16-byte slot boundary.
- A miss carries zero fields.
- The translation keeps the low nibble of the address.

The exact hash, the base alignment for each table size, the field unpacking and the response latency can only be shown by the bench scenarios. These sweep every channel and every table size with expected addresses and fields computed arithmetically.

// File: rtl/obj_lookup_pkg.sv
package obj_lookup_pkg;
  localparam int NAME_W  = 32;
  localparam int HASH_W  = 8;
  localparam int SLOT_SH = 4;   // 16-byte slots
  localparam int MIN_TSH = 12;  // smallest table is 4 KB

  localparam int INST_LSB = 0;
  localparam int INST_W   = 16;
  localparam int CLS_LSB  = 16;
  localparam int CLS_W    = 7;
  localparam int SUB_LSB  = 24;
  localparam int SUB_W    = 3;
  localparam int CH_LSB   = 28;
  localparam int CH_W     = 3;
  localparam int SW_BIT   = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_NAME,
    ST_RD_DESC,
    ST_EVAL,
    ST_RESP
  } lk_state_e;

  typedef struct packed {
    logic              sw;
    logic [CH_W-1:0]   chan;
    logic [SUB_W-1:0]  subch;
    logic [CLS_W-1:0]  cls;
    logic [INST_W-1:0] inst;
  } obj_ctx_t;
endpackage

// File: rtl/obj_hash.sv
module obj_hash
  import obj_lookup_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int MEM_AW = 22
) (
  input  logic [NAME_W-1:0] name_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [MEM_AW-1:0] base_i,
  input  logic [1:0]        size_i,
  output logic [MEM_AW-1:0] slot_o
);
  localparam int NBYTES = NAME_W / 8;
  localparam int OFF_W  = HASH_W + SLOT_SH;

  logic [HASH_W-1:0] hash;
  logic [MEM_AW-1:0] size_mask;
  logic [MEM_AW-1:0] offset;

  always_comb begin
    hash = HASH_W'(chan_i);
    for (int b = 0; b < NBYTES; b++) hash ^= name_i[b*8 +: 8];
  end

  assign size_mask = (MEM_AW'(1) << (MIN_TSH + int'(size_i))) - MEM_AW'(1);
  assign offset    = MEM_AW'({hash, {SLOT_SH{1'b0}}}) & size_mask;
  assign slot_o    = (base_i & ~size_mask) + offset;

  logic unused_w;
  assign unused_w = ^OFF_W;
endmodule

// File: rtl/ctx_decode.sv
module ctx_decode
  import obj_lookup_pkg::*;
(
  input  logic [NAME_W-1:0] req_name_i,
  input  logic [31:0]       mem_name_i,
  input  logic [31:0]       desc_i,
  output logic              hit_o,
  output obj_ctx_t          ctx_o
);
  obj_ctx_t raw;

  assign raw.sw    = desc_i[SW_BIT];
  assign raw.chan  = desc_i[CH_LSB  +: CH_W];
  assign raw.subch = desc_i[SUB_LSB +: SUB_W];
  assign raw.cls   = desc_i[CLS_LSB +: CLS_W];
  assign raw.inst  = desc_i[INST_LSB +: INST_W];

  assign hit_o = (mem_name_i == req_name_i) && (desc_i != '0);
  assign ctx_o = hit_o ? raw : '0;
endmodule

// File: rtl/inst_xlat.sv
module inst_xlat #(
  parameter int MEM_AW = 22
) (
  input  logic [MEM_AW-1:0] addr_i,
  output logic [MEM_AW-1:0] addr_o
);
  localparam logic [MEM_AW-1:0] FLIP = {{(MEM_AW-4){1'b1}}, 4'b0000};
  assign addr_o = addr_i ^ FLIP;
endmodule

// File: rtl/obj_lookup.sv
module obj_lookup
  import obj_lookup_pkg::*;
#(
  parameter int CHAN_W = 3,
  parameter int MEM_AW = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [31:0]       req_name_i,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic [MEM_AW-1:0] tbl_base_i,
  input  logic [1:0]        tbl_size_i,
  output logic              mem_rd_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  input  logic [31:0]       mem_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_sw_o,
  output logic [2:0]        rsp_chan_o,
  output logic [2:0]        rsp_subch_o,
  output logic [6:0]        rsp_class_o,
  output logic [15:0]       rsp_inst_o,
  input  logic [MEM_AW-1:0] xlat_addr_i,
  output logic [MEM_AW-1:0] xlat_addr_o
);
  lk_state_e         state_q, state_d;
  logic [31:0]       name_q, mem_name_q;
  logic [MEM_AW-1:0] slot_q, slot_d;
  logic              hit_d, hit_q;
  obj_ctx_t          ctx_d, ctx_q;
  logic              accept;

  obj_hash #(.CHAN_W(CHAN_W), .MEM_AW(MEM_AW)) u_hash (
    .name_i (req_name_i),
    .chan_i (req_chan_i),
    .base_i (tbl_base_i),
    .size_i (tbl_size_i),
    .slot_o (slot_d)
  );

  ctx_decode u_dec (
    .req_name_i (name_q),
    .mem_name_i (mem_name_q),
    .desc_i     (mem_data_i),
    .hit_o      (hit_d),
    .ctx_o      (ctx_d)
  );

  inst_xlat #(.MEM_AW(MEM_AW)) u_xlat (
    .addr_i (xlat_addr_i),
    .addr_o (xlat_addr_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_RD_NAME;
      ST_RD_NAME: state_d = ST_RD_DESC;
      ST_RD_DESC: state_d = ST_EVAL;
      ST_EVAL:    state_d = ST_RESP;
      ST_RESP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      name_q     <= '0;
      slot_q     <= '0;
      mem_name_q <= '0;
      hit_q      <= 1'b0;
      ctx_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        name_q <= req_name_i;
        slot_q <= slot_d;
      end
      // name word lands while the descriptor read is issued
      if (state_q == ST_RD_DESC) mem_name_q <= mem_data_i;
      if (state_q == ST_EVAL) begin
        hit_q <= hit_d;
        ctx_q <= ctx_d;
      end
    end
  end

  assign mem_rd_o    = (state_q == ST_RD_NAME) || (state_q == ST_RD_DESC);
  assign mem_addr_o  = (state_q == ST_RD_DESC) ? slot_q + MEM_AW'(4) : slot_q;

  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_hit_o   = hit_q;
  assign rsp_sw_o    = ctx_q.sw;
  assign rsp_chan_o  = ctx_q.chan;
  assign rsp_subch_o = ctx_q.subch;
  assign rsp_class_o = ctx_q.cls;
  assign rsp_inst_o  = ctx_q.inst;
endmodule

// File: rtl/obj_lookup_chk.sv
module obj_lookup_chk #(
  parameter int CHAN_W = 3,
  parameter int MEM_AW = 22
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_rd_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_sw_o,
  input logic [2:0]        rsp_chan_o,
  input logic [2:0]        rsp_subch_o,
  input logic [6:0]        rsp_class_o,
  input logic [15:0]       rsp_inst_o,
  input logic [MEM_AW-1:0] xlat_addr_i,
  input logic [MEM_AW-1:0] xlat_addr_o
);
  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_rd_o) |-> !req_ready_o); // R8
  AST_ACCEPT_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_rd_o); // R2
  AST_SECOND_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !$past(mem_rd_o)) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + MEM_AW'(4))); // R2
  AST_SLOT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !$past(mem_rd_o)) |-> (mem_addr_o[3:0] == 4'h0)); // R3
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (!rsp_sw_o && rsp_chan_o == 3'd0 && rsp_subch_o == 3'd0
                                     && rsp_class_o == 7'd0 && rsp_inst_o == 16'd0)); // R7
  AST_XLAT_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_addr_o[3:0] == xlat_addr_i[3:0]); // R9
endmodule

bind obj_lookup obj_lookup_chk #(.CHAN_W(CHAN_W), .MEM_AW(MEM_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_rd_o    (mem_rd_o),
  .mem_addr_o  (mem_addr_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_sw_o    (rsp_sw_o),
  .rsp_chan_o  (rsp_chan_o),
  .rsp_subch_o (rsp_subch_o),
  .rsp_class_o (rsp_class_o),
  .rsp_inst_o  (rsp_inst_o),
  .xlat_addr_i (xlat_addr_i),
  .xlat_addr_o (xlat_addr_o)
);

// File: tb/tb_obj_lookup.sv
module tb_obj_lookup;
  localparam int CLK_P  = 10;
  localparam int CHAN_W = 3;
  localparam int AW     = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_name = '0;
  logic [2:0]    req_chan = '0;
  logic [AW-1:0] tbl_base = '0;
  logic [1:0]    tbl_size = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data = '0;
  logic          rsp_valid, rsp_hit, rsp_sw;
  logic [2:0]    rsp_chan, rsp_subch;
  logic [6:0]    rsp_class;
  logic [15:0]   rsp_inst;
  logic [AW-1:0] xlat_in = '0;
  logic [AW-1:0] xlat_out;

  int total = 0;
  int bad   = 0;

  logic [31:0]   mem [0:(1<<(AW-2))-1];
  logic [AW-1:0] rd_log [0:7];
  int            rd_n = 0;

  always #(CLK_P/2) clk = ~clk;

  obj_lookup #(.CHAN_W(CHAN_W), .MEM_AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_name_i(req_name), .req_chan_i(req_chan),
    .tbl_base_i(tbl_base), .tbl_size_i(tbl_size),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_sw_o(rsp_sw),
    .rsp_chan_o(rsp_chan), .rsp_subch_o(rsp_subch),
    .rsp_class_o(rsp_class), .rsp_inst_o(rsp_inst),
    .xlat_addr_i(xlat_in), .xlat_addr_o(xlat_out)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= mem[mem_addr[AW-1:2]];
      if (rd_n < 8) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hash(input logic [31:0] n, input logic [2:0] c);
    return n[7:0] ^ n[15:8] ^ n[23:16] ^ n[31:24] ^ {5'd0, c};
  endfunction

  function automatic logic [AW-1:0] ref_slot(input logic [31:0] n, input logic [2:0] c,
                                             input logic [AW-1:0] base, input logic [1:0] sz);
    logic [AW-1:0] tsize;
    tsize = AW'(4096) << sz;
    return (base & ~(tsize - 1)) + AW'({ref_hash(n, c), 4'h0});
  endfunction

  // entry: stored name, descriptor; mode 0 hit, 1 name mismatch, 2 zero descriptor
  task automatic lookup(input logic [31:0] n, input logic [2:0] c, input logic [AW-1:0] base,
                        input logic [1:0] sz, input logic [31:0] desc, input int mode);
    logic [AW-1:0] slot;
    int            lat;
    bit            exp_hit;
    slot = ref_slot(n, c, base, sz);
    mem[slot[AW-1:2]]     = (mode == 1) ? (n ^ 32'h0000_0100) : n;
    mem[slot[AW-1:2] + 1] = (mode == 2) ? 32'h0 : desc;
    exp_hit = (mode == 0);
    @(negedge clk);
    rd_n = 0;
    req_name = n; req_chan = c; tbl_base = base; tbl_size = sz;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_name = ~n; req_chan = ~c; tbl_base = ~base;   // disturb after acceptance
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      chk(req_ready == 1'b0, "R8 not ready while busy", req_ready, 0);
      @(negedge clk);
      lat++;
    end
    chk(lat == 4, "R4 response latency", lat, 4);
    chk(req_ready == 1'b0, "R8 not ready in response", req_ready, 0);
    chk(rd_n == 2, "R2 two reads", rd_n, 2);
    chk(rd_log[0] == slot, "R1 R3 slot address", rd_log[0], slot);
    chk(rd_log[1] == slot + AW'(4), "R2 descriptor address", rd_log[1], slot + AW'(4));
    chk(rsp_hit == exp_hit, "R5 hit", rsp_hit, exp_hit);
    if (exp_hit) begin
      chk(rsp_inst == desc[15:0], "R6 inst", rsp_inst, desc[15:0]);
      chk(rsp_class == desc[22:16], "R6 class", rsp_class, desc[22:16]);
      chk(rsp_subch == desc[26:24], "R6 subch", rsp_subch, desc[26:24]);
      chk(rsp_chan == desc[30:28], "R6 chan", rsp_chan, desc[30:28]);
      chk(rsp_sw == desc[31], "R6 sw flag", rsp_sw, desc[31]);
    end else begin
      chk({rsp_sw, rsp_chan, rsp_subch, rsp_class, rsp_inst} == '0, "R7 miss fields zero",
          {rsp_sw, rsp_chan, rsp_subch, rsp_class, rsp_inst}, 0);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R4 single-cycle response", rsp_valid, 0);
    chk(req_ready == 1'b1, "R8 ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << (AW-2)); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R4 reset no response", rsp_valid, 0);
    chk(mem_rd == 1'b0, "R2 reset no read", mem_rd, 0);
    rst_n = 1'b1;
    chk(req_ready == 1'b1, "R8 ready out of reset", req_ready, 1);

    for (int c = 0; c < 8; c++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int k = 0; k < 3; k++) begin
          logic [31:0]   n;
          logic [31:0]   d;
          logic [AW-1:0] b;
          n = 32'h1000 + 32'h0102_0305 * (c * 13 + sz * 5 + k + 1);
          b = AW'(16'h3A5C * (k + 1) + 16'h0770 * sz);
          d = {k[0], 3'(c + k), 1'b0, 3'(sz + k), 1'b0, 7'(c * 11 + sz), 16'(n[15:0] ^ 16'h5A5A)};
          lookup(n, 3'(c), b, 2'(sz), d, 0);
        end
      end
    end

    // R5 miss by name, miss by empty descriptor, across channels
    for (int c = 0; c < 8; c++) begin
      lookup(32'hDEAD_0000 + 32'(c), 3'(c), 16'h8000, 2'd1, 32'h1234_5678, 1);
      lookup(32'hBEEF_0000 + 32'(c * 7), 3'(c), 16'h4000, 2'd2, 32'h0, 2);
    end
    // R5 single non-zero descriptor bit is enough for a hit
    lookup(32'hFFFF_FFFF, 3'd7, 16'hFFFF, 2'd3, 32'h8000_0000, 0);
    lookup(32'h0000_0000, 3'd0, 16'h0000, 2'd0, 32'h0000_0001, 0);

    // R9 translation sweep
    for (int a = 0; a < 64; a++) begin
      logic [AW-1:0] x;
      x = AW'(a * 16'h0413 + 16'h0007);
      @(negedge clk);
      xlat_in = x;
      #1;
      chk(xlat_out == (x ^ 16'hFFF0), "R9 translate", xlat_out, x ^ 16'hFFF0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule